// File: doc/BRIEF.md
# DRAM current-test command sequencer

This block drives an SDRAM command bus with one of two repeating, timing-exact patterns used while measuring supply current. In single-bank mode it opens one row in bank 0, reads it, and closes it again. The pattern repeats at the minimum row cycle. In four-bank mode it interleaves row activations and reads with auto-precharge across banks 0 to 3 on a fixed ten-clock schedule.

Every clock the block presents a command code, a bank number, a row/column address and an auto-precharge flag. Addresses come from a 16-bit pseudo-random generator, so each pass through a pattern touches fresh rows and columns. The two modes treat the address lines differently on idle cycles. Single-bank mode keeps them toggling every clock. Four-bank mode keeps them quiet.

The mode select is sampled only at a period boundary. All spacings are parameters.

Top module: `dram_itest_seq`

## Requirements
- R1: While reset is asserted the outputs are command NOP (code 0), bank 0, address 0 and auto-precharge flag 0, regardless of enable.
- R2: While enable is sampled low the block issues NOP (code 0) and clears the auto-precharge flag, and bank and address hold. The first command after enable is sampled high is an Activate (code 1) and starts the pattern from its first slot.
- R3: In single-bank mode (mode select 0) each period is TRC=11 clocks. It has Activate (code 1) in slot 0, Read (code 2) in slot TRCD=3, Precharge (code 3) in slot TRAS=8, and NOP in every other slot. Every command targets bank 0.
- R4: In single-bank mode the address changes on every enabled clock. On a NOP slot it becomes the bitwise inverse of its previous value.
- R5: In four-bank mode (mode select 1) each 10-clock period runs, by slot: ACT b0, NOP, ACT b1, RD b0, ACT b2, RD b1, ACT b3, RD b2, NOP, RD b3. Activates are TRRD=2 apart, each Read follows its bank's Activate by TRCD, and no Precharge is issued.
- R6: In four-bank mode, bank, address and auto-precharge flag hold their previous values on NOP slots.
- R7: The auto-precharge flag is 1 on every four-bank Read. It is 0 on every Activate, on every Precharge, and on every single-bank command.
- R8: A command's address is the low 13 bits of a 16-bit shift register. The register is seeded 0xACE1 and shifts left, taking bit15^bit13^bit12^bit10 into bit 0. It advances once per non-NOP command. In single-bank mode, a value equal to the previous address is inverted.
- R9: A change of mode select takes effect only at a period boundary, and the new pattern starts from its first slot.
- R10: The command code is always one of NOP=0, ACT=1, RD=2, PRE=3. No write is ever issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run the pattern when high |
| mode_i | input | 1 | 0 = single-bank pattern, 1 = four-bank interleave |
| cmd_o | output | 3 | Command code (NOP=0, ACT=1, RD=2, PRE=3) |
| bank_o | output | BANK_W (2) | Target bank |
| addr_o | output | ADDR_W (13) | Row or column address |
| ap_o | output | 1 | Auto-precharge flag |

## Verification
The bench builds the block with its default values: TRCD 3, TRAS 8, TRC 11, TRRD 2, four banks, a 13-bit address and seed 0xACE1. These values make the four-bank schedule dense, with an Activate and a Read in alternate slots and only two idle slots per period. Any misplaced offset therefore collides visibly. They also give the single-bank period long NOP runs, which expose the address-toggle rule. Mode changes are applied mid-period in both directions, so the boundary latch and the restart at slot 0 are both observed against a model that steps its own copy of the shift register.

// File: rtl/itest_pkg.sv
package itest_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_PRE = 3'd3
  } cmd_e;

  typedef enum logic {
    MODE_ONE  = 1'b0,
    MODE_QUAD = 1'b1
  } mode_e;

  localparam int unsigned RND_W = 16;

  // Fibonacci step for x^16 + x^14 + x^13 + x^11 + 1
  function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
    return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Length of one four-bank interleave period
  function automatic int unsigned quad_period(input int unsigned banks,
                                              input int unsigned trrd,
                                              input int unsigned trcd);
    return (banks - 1) * trrd + trcd + 1;
  endfunction

endpackage

// File: rtl/itest_lfsr.sv
module itest_lfsr
  import itest_pkg::*;
#(
  parameter logic [RND_W-1:0] SEED  = 16'hACE1,
  parameter int unsigned      OUT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [OUT_W-1:0] rnd_o
);

  logic [RND_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED;
    end else if (step_i) begin
      state_q <= rnd_step(state_q);
    end
  end

  assign rnd_o = state_q[OUT_W-1:0];

  AST_RND_NEVER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0); // R8
  AST_RND_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state_q)); // R8

endmodule

// File: rtl/itest_timer.sv
module itest_timer
  import itest_pkg::*;
#(
  parameter int unsigned ONE_PERIOD  = 11,
  parameter int unsigned QUAD_PERIOD = 10,
  parameter int unsigned CW          = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          mode_i,
  output logic [CW-1:0] slot_o,
  output logic          mode_o,
  output logic          start_o
);

  localparam logic [CW-1:0] ONE_END  = CW'(ONE_PERIOD);
  localparam logic [CW-1:0] QUAD_END = CW'(QUAD_PERIOD);

  logic          run_q;
  logic          mode_q;
  logic [CW-1:0] pos_q;
  logic [CW-1:0] end_pos;

  assign end_pos = (mode_q == MODE_QUAD) ? QUAD_END : ONE_END;
  assign start_o = !run_q || (pos_q == end_pos);
  assign slot_o  = start_o ? '0 : pos_q;
  assign mode_o  = start_o ? mode_i : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= MODE_ONE;
      pos_q  <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      pos_q <= '0;
    end else begin
      run_q  <= 1'b1;
      mode_q <= mode_o;
      pos_q  <= slot_o + 1'b1;
    end
  end

  AST_MODE_ONLY_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_o) |=> $stable(mode_q)); // R9
  AST_SLOT_INSIDE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o < ((mode_o == MODE_QUAD) ? QUAD_END : ONE_END)); // R9

endmodule

// File: rtl/itest_pattern.sv
module itest_pattern
  import itest_pkg::*;
#(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned TRCD   = 3,
  parameter int unsigned TRAS   = 8,
  parameter int unsigned TRRD   = 2,
  parameter int unsigned CW     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     slot_i,
  input  logic              mode_i,
  output cmd_e              cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              ap_o
);

  logic [BANKS-1:0] act_hit;
  logic [BANKS-1:0] rd_hit;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign act_hit[b] = (slot_i == CW'(b * TRRD));
    assign rd_hit[b]  = (slot_i == CW'(b * TRRD + TRCD));
  end

  always_comb begin
    cmd_o  = CMD_NOP;
    bank_o = '0;
    ap_o   = 1'b0;
    if (mode_i == MODE_ONE) begin
      if (slot_i == '0)              cmd_o = CMD_ACT;
      else if (slot_i == CW'(TRCD))  cmd_o = CMD_RD;
      else if (slot_i == CW'(TRAS))  cmd_o = CMD_PRE;
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (act_hit[b]) begin
          cmd_o  = CMD_ACT;
          bank_o = BANK_W'(b);
        end
        if (rd_hit[b]) begin
          cmd_o  = CMD_RD;
          bank_o = BANK_W'(b);
          ap_o   = 1'b1;
        end
      end
    end
  end

  AST_QUAD_SLOT_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_QUAD) |-> $onehot0({act_hit, rd_hit})); // R5

endmodule

// File: rtl/dram_itest_seq.sv
module dram_itest_seq
  import itest_pkg::*;
#(
  parameter int unsigned      ADDR_W = 13,
  parameter int unsigned      BANKS  = 4,
  parameter int unsigned      BANK_W = 2,
  parameter int unsigned      TRCD   = 3,
  parameter int unsigned      TRAS   = 8,
  parameter int unsigned      TRC    = 11,
  parameter int unsigned      TRRD   = 2,
  parameter logic [RND_W-1:0] SEED   = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mode_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ap_o
);

  localparam int unsigned QUAD_P = quad_period(BANKS, TRRD, TRCD);
  localparam int unsigned MAX_P  = (TRC > QUAD_P) ? TRC : QUAD_P;
  localparam int unsigned CW     = $clog2(MAX_P + 1);

  logic [CW-1:0]     slot;
  logic              eff_mode;
  logic              start;
  cmd_e              pat_cmd;
  logic [BANK_W-1:0] pat_bank;
  logic              pat_ap;
  logic [ADDR_W-1:0] rnd;

  // named events for the checks below
  logic cmd_issue;
  logic eff_one;
  logic nop_quad;

  assign cmd_issue = en_i && (pat_cmd != CMD_NOP);
  assign eff_one   = en_i && (eff_mode == MODE_ONE);
  assign nop_quad  = en_i && (eff_mode == MODE_QUAD) && !cmd_issue;

  itest_timer #(
    .ONE_PERIOD (TRC),
    .QUAD_PERIOD(QUAD_P),
    .CW         (CW)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .mode_i (mode_i),
    .slot_o (slot),
    .mode_o (eff_mode),
    .start_o(start)
  );

  itest_pattern #(
    .BANKS (BANKS),
    .BANK_W(BANK_W),
    .TRCD  (TRCD),
    .TRAS  (TRAS),
    .TRRD  (TRRD),
    .CW    (CW)
  ) u_pattern (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .slot_i(slot),
    .mode_i(eff_mode),
    .cmd_o (pat_cmd),
    .bank_o(pat_bank),
    .ap_o  (pat_ap)
  );

  itest_lfsr #(
    .SEED (SEED),
    .OUT_W(ADDR_W)
  ) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(cmd_issue),
    .rnd_o (rnd)
  );

  // Single-bank commands must always move the address lines
  function automatic logic [ADDR_W-1:0] fresh_addr(input logic [ADDR_W-1:0] r,
                                                   input logic [ADDR_W-1:0] prev,
                                                   input logic               one);
    return (one && (r == prev)) ? ~r : r;
  endfunction

  logic [2:0]        cmd_q,  cmd_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ap_q,   ap_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    bank_d = bank_q;
    addr_d = addr_q;
    ap_d   = ap_q;
    if (!en_i) begin
      ap_d = 1'b0;
    end else if (cmd_issue) begin
      cmd_d  = pat_cmd;
      bank_d = pat_bank;
      addr_d = fresh_addr(rnd, addr_q, eff_one);
      ap_d   = pat_ap;
    end else if (eff_one) begin
      addr_d = ~addr_q;
      ap_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
      ap_q   <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      bank_q <= bank_d;
      addr_q <= addr_d;
      ap_q   <= ap_d;
    end
  end

  assign cmd_o  = cmd_q;
  assign bank_o = bank_q;
  assign addr_o = addr_q;
  assign ap_o   = ap_q;

  AST_IDLE_GIVES_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cmd_o == CMD_NOP) && !ap_o); // R2
  AST_PERIOD_OPENS_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start) |=> (cmd_o == CMD_ACT)); // R2
  AST_ONE_BANK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_one && cmd_issue) |=> (bank_o == '0)); // R3
  AST_ONE_ADDR_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_one |=> (addr_o != $past(addr_o))); // R4
  AST_QUAD_NO_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !eff_one) |=> (cmd_o != CMD_PRE)); // R5
  AST_QUAD_NOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_quad |=> $stable(addr_o) && $stable(bank_o) && $stable(ap_o)); // R6
  AST_AP_ON_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ap_o && (cmd_o != CMD_NOP)) |-> (cmd_o == CMD_RD)); // R7
  AST_ONE_NO_AP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_one |=> !ap_o); // R7
  AST_CMD_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o <= 3'd3); // R10

endmodule

// File: tb/dram_itest_seq_tb.sv
module dram_itest_seq_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [2:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [12:0] addr_o;
  logic        ap_o;

  always #2.5 clk_i = ~clk_i;

  dram_itest_seq u_dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .mode_i(mode_i),
    .cmd_o (cmd_o),
    .bank_o(bank_o),
    .addr_o(addr_o),
    .ap_o  (ap_o)
  );

  typedef struct {
    logic [2:0]  cmd;
    logic [1:0]  bank;
    logic [12:0] addr;
    logic        ap;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  string tag_override = "";

  // independent reference state
  bit          m_run = 0;
  int          m_pos = 0;
  bit          m_mode = 0;
  logic [15:0] m_rnd = 16'hACE1;
  logic [1:0]  m_bank = 0;
  logic [12:0] m_addr = 0;
  logic        m_ap = 0;

  function automatic logic [15:0] ref_step(input logic [15:0] s);
    logic fb;
    fb = ^(s & 16'hB400);
    return {s[14:0], fb};
  endfunction

  task automatic model(input bit en, input bit md, output exp_t e);
    int s;
    int per;
    bit mm;
    logic [2:0] c;
    logic [12:0] r;
    string rq;
    c = 3'd0;
    per = m_mode ? 10 : 11;
    if (!en) begin
      m_run = 0;
      m_pos = 0;
      m_ap = 0;
      rq = "R2 idle";
    end else begin
      if (!m_run || m_pos == per) begin
        s = 0;
        mm = md;
      end else begin
        s = m_pos;
        mm = m_mode;
      end
      m_run = 1;
      m_mode = mm;
      m_pos = s + 1;
      if (!mm) begin
        case (s)
          0: c = 3'd1;
          3: c = 3'd2;
          8: c = 3'd3;
          default: c = 3'd0;
        endcase
      end else begin
        case (s)
          0, 2, 4, 6: begin c = 3'd1; m_bank = 2'(s / 2); end
          3, 5, 7, 9: begin c = 3'd2; m_bank = 2'((s - 3) / 2); end
          default: c = 3'd0;
        endcase
      end
      if (c != 3'd0) begin
        r = m_rnd[12:0];
        if (!mm && r == m_addr) r = ~r;
        m_addr = r;
        m_rnd = ref_step(m_rnd);
        m_ap = mm && (c == 3'd2);
        if (!mm) m_bank = 2'd0;
        rq = mm ? "R5 R7 R8 R10" : "R3 R7 R8 R10";
        if (s == 0) rq = {rq, " R2"};
      end else if (!mm) begin
        m_addr = ~m_addr;
        m_ap = 0;
        rq = "R4 R3";
      end else begin
        rq = "R6 R5";
      end
    end
    if (tag_override != "") rq = {tag_override, " ", rq};
    e.cmd = c;
    e.bank = m_bank;
    e.addr = m_addr;
    e.ap = m_ap;
    e.req = rq;
  endtask

  // driver: applies inputs and pushes the expected result of the next edge
  task automatic drive(input bit en, input bit md, input int n);
    exp_t e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      en_i = en;
      mode_i = md;
      model(en, md, e);
      q.push_back(e);
    end
  endtask

  // monitor: pops one expected item per edge and compares
  always @(posedge clk_i) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_checks++;
      if (cmd_o !== e.cmd || bank_o !== e.bank || addr_o !== e.addr || ap_o !== e.ap) begin
        n_fail++;
        $display("FAIL %s: got cmd=%0d bank=%0d addr=%h ap=%b, expected cmd=%0d bank=%0d addr=%h ap=%b",
                 e.req, cmd_o, bank_o, addr_o, ap_o, e.cmd, e.bank, e.addr, e.ap);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got running, expected finished");
      finish_run();
    end
  end

  initial begin
    // R1: reset state, with enable forced high during reset
    en_i = 1'b1;
    repeat (4) @(posedge clk_i);
    #1;
    n_checks++;
    if (cmd_o !== 3'd0 || bank_o !== 2'd0 || addr_o !== 13'd0 || ap_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got cmd=%0d bank=%0d addr=%h ap=%b, expected cmd=0 bank=0 addr=0000 ap=0",
               cmd_o, bank_o, addr_o, ap_o);
    end
    @(negedge clk_i);
    en_i = 1'b0;
    rst_ni = 1'b1;

    drive(0, 0, 3);            // R2 idle
    drive(1, 0, 25);           // R3 R4 single-bank
    drive(0, 0, 2);            // R2 pause, then restart
    drive(1, 1, 25);           // R5 R6 four-bank
    tag_override = "R9";
    drive(1, 0, 6);            // mode flips mid quad period
    drive(1, 0, 16);
    drive(1, 1, 4);            // flips mid single period
    drive(1, 1, 14);
    tag_override = "";
    drive(0, 1, 3);
    drive(1, 1, 7);
    drive(1, 0, 12);
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    finish_run();
  end

endmodule